// File: doc/BRIEF.md
# DRAM Bank State and Timing Tracker

This block sits in a memory controller's command path. It keeps the open or closed state and the open row of each internal bank of a DDR2-class device. The scheduler offers one candidate command per cycle, and the block answers in the same cycle whether that command may go to the device now. When the scheduler issues a legal command, the block updates the bank state and reloads the timers that govern later commands.

The block checks minimum spacings within a bank and between banks:

- activate to column command;
- activate to precharge;
- activate to activate, both on the same bank and on different banks;
- precharge to activate;
- column to column;
- write to read;
- read or write to precharge;
- refresh to activate;
- mode-register write to any command.

Address bit 10 selects auto-precharge on a column command and close-all on a precharge. All spacings are parameters in clock cycles. Their defaults suit a 3 ns clock.

Top module: `dram_bank_tracker`

## Requirements
- R1: Command codes on `cmd_type` are 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode write, 7 reserved. After reset all banks read closed (`bank_open` all 0) and an idle command is legal.
- R2: A legal activate opens the addressed bank and records the row on `open_row` (bank i at bits [i*ROW_W +: ROW_W]). An activate to a bank that is already open is illegal.
- R3: A read or write to a closed bank is illegal. A read or write to an open bank is illegal until T_RCD (default 5) cycles after its activate.
- R4: Activates to any two banks are at least T_RRD (3) cycles apart. A bank accepts a new activate no sooner than T_RC (20) cycles after its last activate and T_RP (5) cycles after its precharge.
- R5: Column commands are at least T_CCD (2) cycles apart. A read is illegal until T_WTR (3) cycles after the last write.
- R6: A precharge with bit 10 low closes only the addressed bank. When that bank is open, the precharge is illegal until T_RAS (15) cycles after its activate and until T_RTP (3) or T_WR (5) cycles after its last read or write. A precharge with bit 10 low to a closed bank is legal and changes nothing.
- R7: A precharge with bit 10 high closes every bank. It is legal only when every open bank meets its precharge spacings.
- R8: A read or write with bit 10 high closes its bank at once. The next activate to that bank is allowed max(remaining T_RAS, T_RTP or T_WR) + T_RP cycles after the column command, and no earlier than T_RC allows.
- R9: Refresh and mode write are legal only with all banks closed and past their precharge spacing. After a refresh, no activate is legal for T_RFC (35) cycles.
- R10: For T_MRD (2) cycles after a mode write, every command except idle is illegal.
- R11: A command with `cmd_valid` low (device deselected) is reported legal and changes nothing. An issued command that is illegal changes nothing.
- R12: The reserved code 7 is always illegal while `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Device selected; candidate command present |
| cmd_type | input | 3 | Command code (see R1) |
| cmd_bank | input | 2 | Bank address |
| cmd_a10 | input | 1 | Auto-precharge / close-all bit |
| cmd_row | input | ROW_W (14) | Row address for an activate |
| cmd_issue | input | 1 | Scheduler sends the candidate this cycle |
| cmd_legal | output | 1 | Candidate may be sent this cycle |
| bank_open | output | NUM_BANKS (4) | One bit per bank, high when open |
| open_row | output | NUM_BANKS*ROW_W (56) | Open row of each bank |

## Verification
A wrong bank state shows on `bank_open` and `open_row` on the cycle after the command that corrupted it. A wrong state also shows later as a wrong verdict on the next activate or column command to that bank. A timer that is off by one moves the first legal cycle of the dependent command by one cycle. For that reason the bench probes each spacing on the last illegal cycle and then on the first legal one. Auto-precharge and refresh reload long delays, so an error there surfaces only at the end of the window, tens of cycles later.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6,
    CMD_RSV  = 3'd7
  } dbt_cmd_e;

  // One cycle of countdown, floored at zero.
  function automatic int unsigned tick(int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Counter value after an event that forbids the dependent command for
  // 'cycles' cycles, never shortening a wait already pending.
  function automatic int unsigned hold(int unsigned cur, int unsigned cycles);
    int unsigned want;
    want = (cycles == 0) ? 0 : cycles - 1;
    return (cur > want) ? cur : want;
  endfunction

  // Wait before the next activate after an auto-precharge column command:
  // the internal precharge starts when both the active-time window and the
  // column-to-precharge gap have ended, then the precharge period runs.
  function automatic int unsigned ap_wait(int unsigned ras_left,
                                          int unsigned col_gap,
                                          int unsigned trp);
    int unsigned start;
    start = (ras_left > col_gap) ? ras_left : col_gap;
    return start + trp - 1;
  endfunction

endpackage

// File: rtl/dbt_bank.sv
module dbt_bank
  import dbt_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int CW    = 8,
  parameter int T_RCD = 5,
  parameter int T_RAS = 15,
  parameter int T_RC  = 20,
  parameter int T_RP  = 5,
  parameter int T_RTP = 3,
  parameter int T_WR  = 5,
  parameter int T_RFC = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_close,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             do_ap,
  input  logic             do_ref,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok
);

  logic             open_q, open_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [CW-1:0]    rcd_q, rcd_n;   // activate -> column
  logic [CW-1:0]    ras_q, ras_n;   // activate -> precharge
  logic [CW-1:0]    gap_q, gap_n;   // column   -> precharge
  logic [CW-1:0]    act_q, act_n;   // anything -> next activate

  always_comb begin
    open_n = open_q;
    row_n  = row_q;
    rcd_n  = CW'(tick(rcd_q));
    ras_n  = CW'(tick(ras_q));
    gap_n  = CW'(tick(gap_q));
    act_n  = CW'(tick(act_q));
    if (do_act) begin
      open_n = 1'b1;
      row_n  = row_in;
      rcd_n  = CW'(hold(0, T_RCD));
      ras_n  = CW'(hold(0, T_RAS));
      act_n  = CW'(hold(act_n, T_RC));
    end
    if (do_rd || do_wr) begin
      gap_n = CW'(hold(gap_n, do_rd ? T_RTP : T_WR));
      if (do_ap) begin
        open_n = 1'b0;
        act_n  = CW'(hold(act_n, 1 + ap_wait(ras_q,
                        hold(gap_q, do_rd ? T_RTP : T_WR) + 1, T_RP)));
      end
    end
    if (do_close) begin
      open_n = 1'b0;
      act_n  = CW'(hold(act_n, T_RP));
    end
    if (do_ref) act_n = CW'(hold(act_n, T_RFC));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      gap_q  <= '0;
      act_q  <= '0;
    end else begin
      open_q <= open_n;
      row_q  <= row_n;
      rcd_q  <= rcd_n;
      ras_q  <= ras_n;
      gap_q  <= gap_n;
      act_q  <= act_n;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign act_ok = (act_q == '0);
  assign col_ok = (rcd_q == '0);
  assign pre_ok = (ras_q == '0) && (gap_q == '0);

endmodule

// File: rtl/dbt_gap_timers.sv
module dbt_gap_timers
  import dbt_pkg::*;
#(
  parameter int CW    = 8,
  parameter int T_RRD = 3,
  parameter int T_CCD = 2,
  parameter int T_WTR = 3,
  parameter int T_MRD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] load,    // 0 activate, 1 column, 2 write, 3 mode write
  output logic [3:0] clear
);

  localparam int NUM_GAPS = 4;
  localparam int GAP_LEN [NUM_GAPS] = '{T_RRD, T_CCD, T_WTR, T_MRD};

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load[g]) cnt_q <= CW'(hold(tick(cnt_q), GAP_LEN[g]));
      else              cnt_q <= CW'(tick(cnt_q));
    end
    assign clear[g] = (cnt_q == '0);
  end

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14,
  parameter int T_RCD     = 5,
  parameter int T_RP      = 5,
  parameter int T_RAS     = 15,
  parameter int T_RC      = 20,
  parameter int T_RRD     = 3,
  parameter int T_CCD     = 2,
  parameter int T_WTR     = 3,
  parameter int T_RTP     = 3,
  parameter int T_WR      = 5,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 35
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_type,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input  logic                         cmd_a10,
  input  logic [ROW_W-1:0]             cmd_row,
  input  logic                         cmd_issue,
  output logic                         cmd_legal,
  output logic [NUM_BANKS-1:0]         bank_open,
  output logic [NUM_BANKS*ROW_W-1:0]   open_row
);

  localparam int BW = $clog2(NUM_BANKS);
  localparam int CW = $clog2(T_RFC + T_RC + T_RAS + T_WR + T_RTP + T_RP + 2);

  dbt_cmd_e             op;
  logic [NUM_BANKS-1:0] act_ok, col_ok, pre_ok;
  logic [3:0]           gap_clear, gap_load;
  logic                 verdict, fire;

  // Named internal events.
  logic sel_open, sel_act_ok, sel_col_ok, sel_pre_ok;
  logic all_closed, all_idle, close_all_ok;
  logic rrd_ok, ccd_ok, wtr_ok, mrd_ok;

  assign op         = dbt_cmd_e'(cmd_type);
  assign sel_open   = bank_open[cmd_bank];
  assign sel_act_ok = act_ok[cmd_bank];
  assign sel_col_ok = col_ok[cmd_bank];
  assign sel_pre_ok = pre_ok[cmd_bank];
  assign all_closed   = ~|bank_open;
  assign all_idle     = &act_ok;
  assign close_all_ok = &(pre_ok | ~bank_open);
  assign rrd_ok = gap_clear[0];
  assign ccd_ok = gap_clear[1];
  assign wtr_ok = gap_clear[2];
  assign mrd_ok = gap_clear[3];

  always_comb begin
    unique case (op)
      CMD_IDLE: verdict = 1'b1;
      CMD_ACT:  verdict = mrd_ok && rrd_ok && !sel_open && sel_act_ok;
      CMD_RD:   verdict = mrd_ok && sel_open && sel_col_ok && ccd_ok && wtr_ok;
      CMD_WR:   verdict = mrd_ok && sel_open && sel_col_ok && ccd_ok;
      CMD_PRE:  verdict = mrd_ok && (cmd_a10 ? close_all_ok
                                             : (!sel_open || sel_pre_ok));
      CMD_REF,
      CMD_MRS:  verdict = mrd_ok && all_closed && all_idle;
      default:  verdict = 1'b0;
    endcase
  end

  assign cmd_legal = !cmd_valid || verdict;
  assign fire      = cmd_valid && cmd_issue && verdict;

  assign gap_load[0] = fire && (op == CMD_ACT);
  assign gap_load[1] = fire && (op == CMD_RD || op == CMD_WR);
  assign gap_load[2] = fire && (op == CMD_WR);
  assign gap_load[3] = fire && (op == CMD_MRS);

  dbt_gap_timers #(
    .CW(CW), .T_RRD(T_RRD), .T_CCD(T_CCD), .T_WTR(T_WTR), .T_MRD(T_MRD)
  ) u_gaps (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .clear(gap_clear)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BW'(b));

    dbt_bank #(
      .ROW_W(ROW_W), .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_RP(T_RP), .T_RTP(T_RTP), .T_WR(T_WR), .T_RFC(T_RFC)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_act  (fire && op == CMD_ACT && hit),
      .do_close(fire && op == CMD_PRE && (cmd_a10 || hit) && bank_open[b]),
      .do_rd   (fire && op == CMD_RD && hit),
      .do_wr   (fire && op == CMD_WR && hit),
      .do_ap   (cmd_a10),
      .do_ref  (fire && op == CMD_REF),
      .row_in  (cmd_row),
      .open_o  (bank_open[b]),
      .row_o   (open_row[b*ROW_W +: ROW_W]),
      .act_ok  (act_ok[b]),
      .col_ok  (col_ok[b]),
      .pre_ok  (pre_ok[b])
    );
  end

endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_valid,
  input logic [2:0]                   cmd_type,
  input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input logic                         cmd_a10,
  input logic                         cmd_issue,
  input logic                         cmd_legal,
  input logic [NUM_BANKS-1:0]         bank_open
);

  logic sent;
  assign sent = cmd_valid && cmd_issue && cmd_legal;

  assert_deselect_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_legal);

  assert_refused_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_issue && !cmd_legal) |=> $stable(bank_open));

  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && cmd_type == 3'd1) |=> bank_open[$past(cmd_bank)]);

  assert_col_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_type == 3'd2 || cmd_type == 3'd3) && cmd_legal)
      |-> bank_open[cmd_bank]);

  assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && cmd_type == 3'd1) |=>
      !(cmd_valid && cmd_type == 3'd2 && cmd_bank == $past(cmd_bank) && cmd_legal));

  assert_close_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && cmd_type == 3'd4 && cmd_a10) |=> (bank_open == '0));

  assert_mrd_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && cmd_type == 3'd6) |=> !(cmd_valid && cmd_type != 3'd0 && cmd_legal));

  assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 3'd7) |-> !cmd_legal);

endmodule

bind dram_bank_tracker dbt_checker #(.NUM_BANKS(NUM_BANKS)) i_dbt_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
  .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_issue(cmd_issue),
  .cmd_legal(cmd_legal), .bank_open(bank_open)
);

// File: tb/test_dram_bank_tracker.sv
module test_dram_bank_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int RW = 14;

  localparam logic [2:0] IDLE = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5, MRS = 3'd6, RSV = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_type = IDLE;
  logic [1:0]    cmd_bank = '0;
  logic          cmd_a10 = 1'b0;
  logic [RW-1:0] cmd_row = '0;
  logic          cmd_issue = 1'b0;
  logic          cmd_legal;
  logic [NB-1:0] bank_open;
  logic [NB*RW-1:0] open_row;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 verdict, 1 open vector, 2 row of a bank
    int          bank;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t scb[$];
  event  ev_sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_bank_tracker i_dram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_row(cmd_row),
    .cmd_issue(cmd_issue), .cmd_legal(cmd_legal), .bank_open(bank_open),
    .open_row(open_row)
  );

  // Monitor: drains the scoreboard whenever the driver signals a sample point.
  initial begin
    forever begin
      @(ev_sample);
      while (scb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = scb.pop_front();
        case (it.kind)
          0:       act = {31'd0, cmd_legal};
          1:       act = {28'd0, bank_open};
          default: act = {18'd0, open_row[it.bank*RW +: RW]};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h t=%0t",
                   it.req, it.kind, act, it.exp, $time);
        end
      end
    end
  end

  // One cycle: drive at the falling edge, check the verdict shortly after.
  task automatic step(input logic [2:0] op, input int bank, input bit a10,
                      input int row, input bit valid, input bit exp_ok,
                      input string req);
    item_t it;
    @(negedge clk);
    cmd_valid = valid;
    cmd_type  = op;
    cmd_bank  = 2'(bank);
    cmd_a10   = a10;
    cmd_row   = RW'(row);
    cmd_issue = 1'b1;
    #1;
    it.kind = 0; it.bank = 0; it.exp = {31'd0, exp_ok}; it.req = req;
    scb.push_back(it);
    -> ev_sample;
    #0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(IDLE, 0, 0, 0, 1, 1, "R1");
  endtask

  // State checks in the same cycle as the preceding step.
  task automatic see_open(input logic [NB-1:0] exp, input string req);
    item_t it;
    it.kind = 1; it.bank = 0; it.exp = {28'd0, exp}; it.req = req;
    scb.push_back(it);
    -> ev_sample;
    #0;
  endtask

  task automatic see_row(input int bank, input int exp, input string req);
    item_t it;
    it.kind = 2; it.bank = bank; it.exp = 32'(exp); it.req = req;
    scb.push_back(it);
    -> ev_sample;
    #0;
  endtask

  initial begin
    #(CLK_PERIOD * 4000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // c0: reset state, then activate bank 0
    step(ACT, 0, 0, 'h123, 1, 1, "R2");
    see_open(4'b0000, "R1 reset closed");
    step(ACT, 1, 0, 'h2AA, 1, 0, "R4 rrd");          // c1
    step(ACT, 1, 0, 'h2AA, 1, 0, "R4 rrd last");     // c2
    step(ACT, 1, 0, 'h2AA, 1, 1, "R4 rrd first");    // c3
    step(RD,  0, 0, 0, 1, 0, "R3 rcd last");         // c4
    step(RD,  0, 0, 0, 1, 1, "R3 rcd first");        // c5
    step(RD,  0, 0, 0, 1, 0, "R5 ccd");              // c6
    step(WR,  0, 0, 0, 1, 1, "R5 ccd first");        // c7
    step(IDLE,0, 0, 0, 1, 1, "R1");                  // c8
    see_open(4'b0011, "R2 open vector");
    see_row(0, 'h123, "R2 row b0");
    see_row(1, 'h2AA, "R2 row b1");
    step(RD,  1, 0, 0, 1, 0, "R5 wtr last");         // c9
    step(RD,  1, 0, 0, 1, 1, "R5 wtr first");        // c10
    step(PRE, 0, 0, 0, 1, 0, "R6 ras");              // c11
    idle(2);                                         // c12,c13
    step(PRE, 0, 0, 0, 1, 0, "R6 ras last");         // c14
    step(PRE, 0, 0, 0, 1, 1, "R6 ras first");        // c15
    step(ACT, 0, 0, 'h55, 1, 0, "R4 rp/rc");         // c16
    see_open(4'b0010, "R6 single close");
    step(RD,  0, 0, 0, 1, 0, "R3 closed bank");      // c17
    step(PRE, 2, 1, 0, 1, 1, "R7 close all");        // c18
    step(REF, 0, 0, 0, 1, 0, "R9 banks not idle");   // c19
    see_open(4'b0000, "R7 all closed");
    idle(3);                                         // c20..c22
    step(REF, 0, 0, 0, 1, 1, "R9 refresh");          // c23
    step(MRS, 0, 0, 0, 1, 0, "R9 mrs during rfc");   // c24
    idle(32);                                        // c25..c56
    step(ACT, 2, 0, 'h3FF, 1, 0, "R9 rfc last");     // c57
    step(MRS, 0, 0, 0, 1, 1, "R9 mrs");              // c58
    step(ACT, 2, 0, 'h3FF, 1, 0, "R10 mrd");         // c59
    step(ACT, 2, 0, 'h3FF, 1, 1, "R10 mrd first");   // c60
    idle(2);                                         // c61,c62
    step(ACT, 2, 0, 'h111, 1, 0, "R2 already open"); // c63
    step(IDLE,0, 0, 0, 1, 1, "R1");                  // c64
    see_open(4'b0100, "R11 refused act");
    see_row(2, 'h3FF, "R11 row kept");
    step(RD,  2, 1, 0, 1, 1, "R8 read ap");          // c65
    step(WR,  2, 0, 0, 1, 0, "R8 closed after ap");  // c66
    see_open(4'b0000, "R8 ap closes");
    idle(12);                                        // c67..c78
    step(ACT, 2, 0, 'h0F0, 1, 0, "R8 ap last");      // c79
    step(ACT, 2, 0, 'h0F0, 1, 1, "R8 ap first");     // c80
    step(ACT, 3, 0, 'h001, 0, 1, "R11 deselected");  // c81
    step(RSV, 0, 0, 0, 1, 0, "R12 reserved");        // c82
    see_open(4'b0100, "R11 deselect no effect");
    see_row(2, 'h0F0, "R8 reopened row");
    step(PRE, 3, 0, 0, 1, 1, "R6 closed bank noop"); // c83
    step(IDLE,0, 0, 0, 1, 1, "R1");                  // c84
    see_open(4'b0100, "R6 noop keeps state");
    @(negedge clk);
    -> ev_sample;
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule